// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a physical address. It reads a two-level page table held in ordinary memory. A logical address has three fields. The top ten bits pick an entry in the outer table. The next ten bits pick an entry in an inner table. The low twelve bits are a byte offset inside a 4 KB page. The outer table starts at the base address given on a configuration input. Each entry is one 32-bit word.

A request is taken only when the walker is idle. The outer index is first compared with a length setting. An index at or above that length is refused at once and no memory is read. Otherwise the walker makes up to two dependent reads through a word-read port, one for each table level. The memory may answer after any number of cycles. Each response reports either the physical address or a fault code. A fault code names the cause: a range failure, an invalid outer entry or an invalid inner entry. The response also carries the logical address that was walked.

Entry layout: bit 0 is the valid flag (1 means valid). Bits 31:12 hold a 4 KB-aligned address. In an outer entry that address is the base of the next table. In an inner entry it is the frame number.

Top module: `pt_walker`

## Requirements
- R1: After reset, reqReady is 1 and rspValid and memReq are both 0.
- R2: An accepted logical address whose bits 31:22, read as an unsigned number, are greater than or equal to cfgLen causes no memory read. It gives a response with rspCode 2'd1 in the cycle right after acceptance.
- R3: The first read of a walk uses address cfgBase + 4 × (logical bits 31:22).
- R4: If the first read returns a word with bit 0 clear, the walk ends after that one read. The response has rspCode 2'd2.
- R5: The second read uses address {first word[31:12], 12'h000} + 4 × (logical bits 21:12).
- R6: If the second read returns a word with bit 0 clear, the walk ends after two reads. The response has rspCode 2'd3.
- R7: A successful walk gives rspCode 2'd0 and rspPaddr = {second word[31:12], logical bits 11:0}. On any fault, rspPaddr is 0.
- R8: rspValid is high for exactly one cycle per accepted request, and rspVaddr then equals the accepted logical address.
- R9: Only one walk runs at a time. reqReady is 0 from the cycle after acceptance through the response cycle. It returns to 1 in the cycle after the response. A request presented while reqReady is 0 starts no reads.
- R10: memReq is a one-cycle pulse per read, and the result does not depend on how many cycles memory takes to answer.
- R11: cfgBase and cfgLen are captured when a request is accepted. Changing them during a walk has no effect on that walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cfgBase | input | 32 | Physical start of the outer table |
| cfgLen | input | 11 | Number of valid outer entries (0 to 1024) |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Walker idle and able to take a request |
| reqVaddr | input | 32 | Logical address to translate |
| rspValid | output | 1 | One-cycle response strobe |
| rspCode | output | 2 | 0 ok, 1 range fault, 2 outer invalid, 3 inner invalid |
| rspPaddr | output | 32 | Physical address (0 on a fault) |
| rspVaddr | output | 32 | Logical address this response belongs to |
| memReq | output | 1 | One-cycle read strobe |
| memAddr | output | 32 | Byte address of the word to read, valid with memReq |
| memRspValid | input | 1 | Read data present |
| memRspData | input | 32 | Read data word |

## Verification
The bench builds the walker with its default 10/10/12 field split, so the full 32-bit logical range can be driven. With cfgLen at 1024, the last outer and inner indices (both 1023) can be reached. This exercises the carry into the top of the entry address and an all-ones physical result. With the same split, a length of 8 puts the range boundary between outer index 7 and 8. A length of 0 makes every request fault. The memory model answers after 1 or 7 cycles. This shows that the walk does not depend on latency, and it leaves room to change the configuration inputs while a read is waiting.

// File: rtl/ptw_pkg.sv
`timescale 1ns/1ps
package ptw_pkg;

  typedef enum logic [1:0] {
    RSP_OK    = 2'd0,
    RSP_RANGE = 2'd1,
    RSP_OUTER = 2'd2,
    RSP_INNER = 2'd3
  } rspCode_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OUTER_REQ,
    ST_OUTER_WAIT,
    ST_INNER_REQ,
    ST_INNER_WAIT,
    ST_DONE
  } walkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic takeReq;    // capture logical address and table base
    logic takeOuter;  // capture next-table base from read data
    logic takeInner;  // capture frame number from read data
    logic useInner;   // steer memAddr to the inner entry
  } dpCtl_t;

endpackage

// File: rtl/pt_walk_dp.sv
`timescale 1ns/1ps
module pt_walk_dp
  import ptw_pkg::*;
#(
  parameter int OUTER_W   = 10,
  parameter int INNER_W   = 10,
  parameter int OFF_W     = 12,
  parameter int ENTRY_LOG2 = 2,
  localparam int ADDR_W   = OUTER_W + INNER_W + OFF_W,
  localparam int FRAME_W  = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [OUTER_W:0]  cfgLen,
  input  logic [ADDR_W-1:0] memRspData,
  output logic              rangeBad,
  output logic              entryValid,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] vaddrQ,
  output logic [ADDR_W-1:0] paddr
);

  logic [ADDR_W-1:0]  baseQ;
  logic [FRAME_W-1:0] nextBaseQ;
  logic [FRAME_W-1:0] frameQ;
  logic [OUTER_W-1:0] outerIdx;
  logic [INNER_W-1:0] innerIdx;
  logic [ADDR_W-1:0]  outerAddr;
  logic [ADDR_W-1:0]  innerAddr;
  logic               unusedBits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaddrQ    <= '0;
      baseQ     <= '0;
      nextBaseQ <= '0;
      frameQ    <= '0;
    end else begin
      if (ctl.takeReq) begin
        vaddrQ <= reqVaddr;
        baseQ  <= cfgBase;
      end
      if (ctl.takeOuter) nextBaseQ <= memRspData[ADDR_W-1:OFF_W];
      if (ctl.takeInner) frameQ    <= memRspData[ADDR_W-1:OFF_W];
    end
  end

  always_comb begin
    outerIdx  = vaddrQ[ADDR_W-1 -: OUTER_W];
    innerIdx  = vaddrQ[OFF_W +: INNER_W];
    outerAddr = baseQ + (ADDR_W'(outerIdx) << ENTRY_LOG2);
    innerAddr = {nextBaseQ, {OFF_W{1'b0}}} + (ADDR_W'(innerIdx) << ENTRY_LOG2);
    memAddr   = ctl.useInner ? innerAddr : outerAddr;
    paddr     = {frameQ, vaddrQ[OFF_W-1:0]};
    rangeBad  = {1'b0, reqVaddr[ADDR_W-1 -: OUTER_W]} >= cfgLen;
    entryValid = memRspData[0];
  end

  assign unusedBits = ^memRspData[OFF_W-1:1];

endmodule

// File: rtl/pt_walk_ctrl.sv
`timescale 1ns/1ps
module pt_walk_ctrl
  import ptw_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     rangeBad,
  input  logic     memRspValid,
  input  logic     entryValid,
  output dpCtl_t   ctl,
  output logic     reqReady,
  output logic     memReq,
  output logic     rspValid,
  output rspCode_t rspCode
);

  walkState_t state, stateNext;
  rspCode_t   codeQ, codeNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      codeQ <= RSP_OK;
    end else begin
      state <= stateNext;
      codeQ <= codeNext;
    end
  end

  always_comb begin
    stateNext = state;
    codeNext  = codeQ;
    ctl       = '0;
    reqReady  = 1'b0;
    memReq    = 1'b0;
    rspValid  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          ctl.takeReq = 1'b1;
          codeNext    = rangeBad ? RSP_RANGE : RSP_OK;
          stateNext   = rangeBad ? ST_DONE : ST_OUTER_REQ;
        end
      end
      ST_OUTER_REQ: begin
        memReq    = 1'b1;
        stateNext = ST_OUTER_WAIT;
      end
      ST_OUTER_WAIT: begin
        if (memRspValid) begin
          ctl.takeOuter = 1'b1;
          if (entryValid) begin
            stateNext = ST_INNER_REQ;
          end else begin
            codeNext  = RSP_OUTER;
            stateNext = ST_DONE;
          end
        end
      end
      ST_INNER_REQ: begin
        memReq       = 1'b1;
        ctl.useInner = 1'b1;
        stateNext    = ST_INNER_WAIT;
      end
      ST_INNER_WAIT: begin
        ctl.useInner = 1'b1;
        if (memRspValid) begin
          ctl.takeInner = 1'b1;
          if (!entryValid) codeNext = RSP_INNER;
          stateNext = ST_DONE;
        end
      end
      ST_DONE: begin
        rspValid  = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign rspCode = codeQ;

endmodule

// File: rtl/pt_walker.sv
`timescale 1ns/1ps
module pt_walker
  import ptw_pkg::*;
#(
  parameter int OUTER_W    = 10,
  parameter int INNER_W    = 10,
  parameter int OFF_W      = 12,
  parameter int ENTRY_LOG2 = 2,
  localparam int ADDR_W    = OUTER_W + INNER_W + OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [OUTER_W:0]  cfgLen,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqVaddr,
  output logic              rspValid,
  output logic [1:0]        rspCode,
  output logic [ADDR_W-1:0] rspPaddr,
  output logic [ADDR_W-1:0] rspVaddr,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memRspValid,
  input  logic [ADDR_W-1:0] memRspData
);

  dpCtl_t            ctl;
  logic              rangeBad;
  logic              entryValid;
  logic [ADDR_W-1:0] paddr;
  rspCode_t          code;

  pt_walk_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .rangeBad    (rangeBad),
    .memRspValid (memRspValid),
    .entryValid  (entryValid),
    .ctl         (ctl),
    .reqReady    (reqReady),
    .memReq      (memReq),
    .rspValid    (rspValid),
    .rspCode     (code)
  );

  pt_walk_dp #(
    .OUTER_W    (OUTER_W),
    .INNER_W    (INNER_W),
    .OFF_W      (OFF_W),
    .ENTRY_LOG2 (ENTRY_LOG2)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .reqVaddr   (reqVaddr),
    .cfgBase    (cfgBase),
    .cfgLen     (cfgLen),
    .memRspData (memRspData),
    .rangeBad   (rangeBad),
    .entryValid (entryValid),
    .memAddr    (memAddr),
    .vaddrQ     (rspVaddr),
    .paddr      (paddr)
  );

  assign rspCode  = code;
  assign rspPaddr = (code == RSP_OK) ? paddr : '0;

endmodule

// File: rtl/pt_walker_chk.sv
`timescale 1ns/1ps
module pt_walker_chk #(
  parameter int OUTER_W = 10,
  parameter int INNER_W = 10,
  parameter int OFF_W   = 12,
  localparam int ADDR_W = OUTER_W + INNER_W + OFF_W
) (
  input logic              clk,
  input logic              rstN,
  input logic [OUTER_W:0]  cfgLen,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ADDR_W-1:0] reqVaddr,
  input logic              rspValid,
  input logic [1:0]        rspCode,
  input logic [ADDR_W-1:0] rspPaddr,
  input logic [ADDR_W-1:0] rspVaddr,
  input logic              memReq
);

  logic accept;
  logic tooFar;
  logic unusedChk;

  assign accept    = reqValid && reqReady;
  assign tooFar    = {1'b0, reqVaddr[ADDR_W-1 -: OUTER_W]} >= cfgLen;
  assign unusedChk = ^{reqVaddr[ADDR_W-OUTER_W-1:0], rspPaddr[ADDR_W-1:OFF_W],
                       rspVaddr[ADDR_W-1:OFF_W]};

  // R2: out-of-range index answers next cycle with a range fault
  a_r2_range_fast: assert property (@(posedge clk) disable iff (!rstN)
    (accept && tooFar) |=> (rspValid && rspCode == 2'd1));

  // R2: out-of-range index never reaches memory
  a_r2_no_read: assert property (@(posedge clk) disable iff (!rstN)
    (accept && tooFar) |=> !memReq);

  // R7: successful translation keeps the page offset
  a_r7_offset_kept: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspCode == 2'd0) |-> (rspPaddr[OFF_W-1:0] == rspVaddr[OFF_W-1:0]));

  // R8: response strobe lasts one cycle
  a_r8_rsp_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R9: busy after acceptance
  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> !reqReady);

  // R9: reads only happen inside a walk
  a_r9_read_in_walk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (!reqReady && !rspValid));

  // R10: read strobe is a single-cycle pulse
  a_r10_req_pulse: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);

endmodule

bind pt_walker pt_walker_chk #(
  .OUTER_W (OUTER_W),
  .INNER_W (INNER_W),
  .OFF_W   (OFF_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cfgLen   (cfgLen),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .reqVaddr (reqVaddr),
  .rspValid (rspValid),
  .rspCode  (rspCode),
  .rspPaddr (rspPaddr),
  .rspVaddr (rspVaddr),
  .memReq   (memReq)
);

// File: tb/sim_pt_walker.sv
`timescale 1ns/1ps
module sim_pt_walker;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] cfgBase = 32'h0001_0000;
  logic [10:0] cfgLen = 11'd8;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqVaddr = '0;
  logic        rspValid;
  logic [1:0]  rspCode;
  logic [31:0] rspPaddr;
  logic [31:0] rspVaddr;
  logic        memReq;
  logic [31:0] memAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;

  int total = 0;
  int bad = 0;
  int lat = 1;
  int readCount = 0;
  logic [31:0] addrLog [0:3];
  logic [31:0] memMap [logic [31:0]];

  always #5 clk = ~clk;

  pt_walker u0 (
    .clk(clk), .rstN(rstN), .cfgBase(cfgBase), .cfgLen(cfgLen),
    .reqValid(reqValid), .reqReady(reqReady), .reqVaddr(reqVaddr),
    .rspValid(rspValid), .rspCode(rspCode), .rspPaddr(rspPaddr),
    .rspVaddr(rspVaddr), .memReq(memReq), .memAddr(memAddr),
    .memRspValid(memRspValid), .memRspData(memRspData)
  );

  function automatic logic [31:0] lookup(input logic [31:0] a);
    return memMap.exists(a) ? memMap[a] : 32'h0;
  endfunction

  // memory model with configurable latency
  initial begin
    forever begin
      @(negedge clk);
      if (memRspValid) memRspValid = 1'b0;
      if (memReq) begin
        logic [31:0] a;
        a = memAddr;
        addrLog[readCount[1:0]] = a;
        readCount++;
        repeat (lat) @(negedge clk);
        memRspValid = 1'b1;
        memRspData  = lookup(a);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // run one walk; returns response fields, cycles from acceptance, busy flag
  task automatic walk(input logic [31:0] va, input bit holdReq,
                      output logic [1:0] code, output logic [31:0] pa,
                      output logic [31:0] rva, output int cycles, output bit busyOk);
    @(negedge clk);
    reqVaddr  = va;
    reqValid  = 1'b1;
    readCount = 0;
    @(negedge clk);
    if (holdReq) reqVaddr = 32'h0000_0000;
    else reqValid = 1'b0;
    cycles = 1;
    busyOk = 1'b1;
    while (!rspValid && cycles < 300) begin
      if (reqReady) busyOk = 1'b0;
      @(negedge clk);
      cycles++;
    end
    reqValid = 1'b0;
    if (reqReady) busyOk = 1'b0;
    code = rspCode;
    pa   = rspPaddr;
    rva  = rspVaddr;
    @(negedge clk);
    if (rspValid || !reqReady) busyOk = 1'b0;
  endtask

  task automatic test_reset;
    chk(reqReady == 1'b1, "R1 reqReady", {31'b0, reqReady}, 32'h1);
    chk(rspValid == 1'b0, "R1 rspValid", {31'b0, rspValid}, 32'h0);
    chk(memReq == 1'b0,   "R1 memReq",   {31'b0, memReq},   32'h0);
  endtask

  task automatic test_translate;
    logic [1:0] c; logic [31:0] p, v; int n; bit b;
    walk(32'h00C0_5123, 1'b0, c, p, v, n, b);
    chk(readCount == 2, "R3 two reads", readCount, 2);
    chk(addrLog[0] == 32'h0001_000C, "R3 outer addr", addrLog[0], 32'h0001_000C);
    chk(addrLog[1] == 32'h0002_0014, "R5 inner addr", addrLog[1], 32'h0002_0014);
    chk(c == 2'd0, "R7 code ok", {30'b0, c}, 32'h0);
    chk(p == 32'hABCD_E123, "R7 paddr", p, 32'hABCD_E123);
    chk(v == 32'h00C0_5123, "R8 vaddr echo", v, 32'h00C0_5123);
    chk(b, "R9 busy window", {31'b0, b}, 32'h1);
  endtask

  task automatic test_outer_invalid;
    logic [1:0] c; logic [31:0] p, v; int n; bit b;
    walk(32'h0100_0456, 1'b0, c, p, v, n, b);
    chk(readCount == 1, "R4 one read", readCount, 1);
    chk(c == 2'd2, "R4 outer fault", {30'b0, c}, 32'h2);
    chk(p == 32'h0, "R7 paddr zero on fault", p, 32'h0);
    chk(v == 32'h0100_0456, "R8 fault vaddr", v, 32'h0100_0456);
  endtask

  task automatic test_inner_invalid;
    logic [1:0] c; logic [31:0] p, v; int n; bit b;
    walk(32'h00C0_6FFF, 1'b0, c, p, v, n, b);
    chk(readCount == 2, "R6 two reads", readCount, 2);
    chk(addrLog[1] == 32'h0002_0018, "R5 inner addr", addrLog[1], 32'h0002_0018);
    chk(c == 2'd3, "R6 inner fault", {30'b0, c}, 32'h3);
  endtask

  task automatic test_range;
    logic [1:0] c; logic [31:0] p, v; int n; bit b;
    walk(32'h0200_0000, 1'b0, c, p, v, n, b);
    chk(readCount == 0, "R2 no read", readCount, 0);
    chk(n == 1, "R2 next cycle", n, 1);
    chk(c == 2'd1, "R2 range fault", {30'b0, c}, 32'h1);
    // last legal index with length 8
    walk(32'h01C0_0ABC, 1'b0, c, p, v, n, b);
    chk(c == 2'd0, "R2 boundary index 7 ok", {30'b0, c}, 32'h0);
    chk(p == 32'h0007_7ABC, "R7 boundary paddr", p, 32'h0007_7ABC);
    // length zero refuses everything
    cfgLen = 11'd0;
    walk(32'h0000_0000, 1'b0, c, p, v, n, b);
    chk(c == 2'd1 && readCount == 0, "R2 zero length", {30'b0, c}, 32'h1);
    cfgLen = 11'd8;
  endtask

  task automatic test_full_range;
    logic [1:0] c; logic [31:0] p, v; int n; bit b;
    cfgLen = 11'd1024;
    walk(32'hFFFF_FFFF, 1'b0, c, p, v, n, b);
    chk(addrLog[0] == 32'h0001_0FFC, "R3 top outer addr", addrLog[0], 32'h0001_0FFC);
    chk(addrLog[1] == 32'h0005_0FFC, "R5 top inner addr", addrLog[1], 32'h0005_0FFC);
    chk(p == 32'hFFFF_FFFF && c == 2'd0, "R7 all-ones paddr", p, 32'hFFFF_FFFF);
    cfgLen = 11'd8;
  endtask

  task automatic test_latency;
    logic [1:0] c; logic [31:0] p, v; int n; bit b;
    lat = 7;
    walk(32'h00C0_5123, 1'b0, c, p, v, n, b);
    chk(p == 32'hABCD_E123 && c == 2'd0, "R10 slow memory", p, 32'hABCD_E123);
    chk(readCount == 2, "R10 one pulse per read", readCount, 2);
    lat = 1;
  endtask

  task automatic test_cfg_change;
    logic [1:0] c; logic [31:0] p, v; int n; bit b;
    lat = 7;
    fork
      walk(32'h00C0_5123, 1'b0, c, p, v, n, b);
      begin
        repeat (4) @(negedge clk);
        cfgBase = 32'h0000_0000;
        cfgLen  = 11'd0;
      end
    join
    chk(addrLog[1] == 32'h0002_0014, "R11 captured base", addrLog[1], 32'h0002_0014);
    chk(p == 32'hABCD_E123 && c == 2'd0, "R11 walk unaffected", p, 32'hABCD_E123);
    cfgBase = 32'h0001_0000;
    cfgLen  = 11'd8;
    lat = 1;
  endtask

  task automatic test_busy;
    logic [1:0] c; logic [31:0] p, v; int n; bit b;
    walk(32'h00C0_5123, 1'b1, c, p, v, n, b);
    chk(b, "R9 reqReady low while busy", {31'b0, b}, 32'h1);
    chk(readCount == 2, "R9 held request ignored", readCount, 2);
    chk(v == 32'h00C0_5123, "R9 first request kept", v, 32'h00C0_5123);
  endtask

  initial begin
    #2_000_000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    memMap[32'h0001_000C] = 32'h0002_0001; // outer 3 -> inner table 0x20000
    memMap[32'h0002_0014] = 32'hABCD_E001; // inner 5 valid
    memMap[32'h0002_0018] = 32'h1234_5000; // inner 6 invalid
    memMap[32'h0001_0010] = 32'h0003_0000; // outer 4 invalid
    memMap[32'h0001_001C] = 32'h0004_0001; // outer 7 -> 0x40000
    memMap[32'h0004_0000] = 32'h0007_7001;
    memMap[32'h0001_0FFC] = 32'h0005_0001; // outer 1023 -> 0x50000
    memMap[32'h0005_0FFC] = 32'hFFFF_F001;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    test_reset;
    test_translate;
    test_outer_invalid;
    test_inner_invalid;
    test_range;
    test_full_range;
    test_latency;
    test_cfg_change;
    test_busy;
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule